// File: doc/BRIEF.md
# Timer Compare Waveform Generator

An 8-bit up-counter with a single compare channel that shapes one output pin. A control register holds a 2-bit output action field and the two low bits of a waveform mode. A separate one-bit register holds the third mode bit. A compare register supplies the match value. Counting advances only in cycles where `tick` is high. The counter can be loaded at any time.

Three counting schemes are offered:
- a free-running wrap;
- clear-on-compare, where the compare value sets the period;
- fast PWM, with TOP either at the counter maximum or at the compare value.

The meaning of the output action field depends on the scheme. Compare-match and overflow strobes let surrounding logic follow the counter.

In fast PWM the compare value is double-buffered, so a write in mid-period cannot produce a glitch. A load of the counter holds off the compare match for one tick, so the load itself does not move the pin.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset the following are all zero: counter, active compare value, control readback, output, output enable and both strobes.
- R2: The control readback holds the output action field in bits 7:6 and the low mode bits in bits 1:0. Bits 5:2 always read zero. The mode is {ext bit, ctl[1:0]}:
  - 000 is free-running;
  - 010 is clear-on-compare;
  - 011 is fast PWM with TOP = 0xFF;
  - 111 is fast PWM with TOP = active compare value;
  - every other code behaves as free-running.
- R3: The counter and the output change only on a tick. A counter write loads the counter in the following cycle, whether or not a tick is present.
- R4: In clear-on-compare mode, an unblocked tick with the counter equal to the compare value makes the counter 0. Otherwise the counter increments and wraps from 0xFF to 0.
- R5: In free-running and clear-on-compare modes, a compare match acts on the output according to the action field:
  - 01 toggles it;
  - 10 clears it;
  - 11 sets it;
  - 00 leaves it alone.
- R6: In fast PWM, action 10 clears the output on match and sets it on the tick at TOP. Action 11 sets it on match and clears it at TOP.
- R7: In fast PWM, action 01 leaves the output unchanged when the ext bit is 0. When the ext bit is 1, action 01 toggles the output on match.
- R8: In fast PWM with the compare value equal to TOP and action bit 7 set, only the TOP action is applied.
- R9: The output enable is high exactly when the action field is nonzero.
- R10: In fast PWM, a compare write becomes active on the tick at TOP. In the other modes it becomes active in the next cycle.
- R11: The match strobe is high for one cycle after an unblocked tick with counter equal to the active compare value. The overflow strobe is high for one cycle after a tick with the counter at TOP (0xFF outside fast PWM).
- R12: A counter write blocks the compare match, and the clear-on-compare reset, on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 8 | Control write data |
| ext_we | input | 1 | Third mode bit write |
| ext_wdata | input | 1 | Third mode bit value |
| cmp_we | input | 1 | Compare value write |
| cmp_wdata | input | W | Compare write data |
| cnt_we | input | 1 | Counter load |
| cnt_wdata | input | W | Counter load value |
| ctl_rdata | output | 8 | Control readback |
| cnt_q | output | W | Counter value |
| cmp_active | output | W | Compare value in use |
| wave_out | output | 1 | Waveform output bit |
| wave_oe | output | 1 | Pin override enable |
| match_stb | output | 1 | Compare match strobe |
| ovf_stb | output | 1 | Overflow strobe |

## Verification
The free-running toggle run covers a full 256-count wrap. It separates the match strobe from the overflow strobe and shows the output toggling once per period. The clear-on-compare runs use a short period with each action code, so clear, set and toggle are told apart. The counter load test distinguishes a blocked match from an ordinary one, because the counter then runs past the compare value to 0xFF. The fast PWM runs cover both TOP choices, a mid-period compare write and the compare-equals-TOP case, which separates the TOP action from the match action.

// File: rtl/tmr_wavegen.sv
module tmr_wavegen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ctl_we,
  input  logic [7:0]   ctl_wdata,
  input  logic         ext_we,
  input  logic         ext_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  output logic [7:0]   ctl_rdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cmp_active,
  output logic         wave_out,
  output logic         wave_oe,
  output logic         match_stb,
  output logic         ovf_stb
);
  localparam logic [W-1:0] MAXV = '1;

  logic [1:0]   act_q, wgl_q;
  logic         ext_q, blk_q, wave_q, ms_q, os_q, wave_d;
  logic [W-1:0] cnt_r, cmp_r, buf_r;

  wire [2:0]   wgm     = {ext_q, wgl_q};
  wire         pwm     = (wgm == 3'b011) || (wgm == 3'b111);
  wire         ctc     = (wgm == 3'b010);
  wire [W-1:0] top_v   = (wgm == 3'b111) ? cmp_r : MAXV;
  wire         hit     = tick && !blk_q && (cnt_r == cmp_r);
  wire         pwm_top = tick && pwm && (cnt_r == top_v);
  wire         ovf     = tick && (pwm ? (cnt_r == top_v) : (cnt_r == MAXV));
  wire         clr     = pwm_top || (ctc && hit);

  always_comb begin
    wave_d = wave_q;
    if (!pwm) begin
      if (hit) begin
        case (act_q)
          2'b01:   wave_d = !wave_q;
          2'b10:   wave_d = 1'b0;
          2'b11:   wave_d = 1'b1;
          default: wave_d = wave_q;
        endcase
      end
    end else begin
      case (act_q)
        2'b01:   if (ext_q && hit) wave_d = !wave_q;
        2'b10:   if (pwm_top) wave_d = 1'b1; else if (hit) wave_d = 1'b0;
        2'b11:   if (pwm_top) wave_d = 1'b0; else if (hit) wave_d = 1'b1;
        default: wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      wgl_q  <= '0;
      ext_q  <= 1'b0;
      cnt_r  <= '0;
      cmp_r  <= '0;
      buf_r  <= '0;
      blk_q  <= 1'b0;
      wave_q <= 1'b0;
      ms_q   <= 1'b0;
      os_q   <= 1'b0;
    end else begin
      if (ctl_we) begin
        act_q <= ctl_wdata[7:6];
        wgl_q <= ctl_wdata[1:0];
      end
      if (ext_we) ext_q <= ext_wdata;

      if (cnt_we)     cnt_r <= cnt_wdata;
      else if (clr)   cnt_r <= '0;
      else if (tick)  cnt_r <= cnt_r + 1'b1;

      if (cnt_we)     blk_q <= 1'b1;
      else if (tick)  blk_q <= 1'b0;

      if (cmp_we) buf_r <= cmp_wdata;
      if (cmp_we && !pwm) cmp_r <= cmp_wdata;
      else if (pwm_top)   cmp_r <= buf_r;

      wave_q <= wave_d;
      ms_q   <= hit;
      os_q   <= ovf;
    end
  end

  assign ctl_rdata  = {act_q, 4'b0000, wgl_q};
  assign cnt_q      = cnt_r;
  assign cmp_active = cmp_r;
  assign wave_out   = wave_q;
  assign wave_oe    = |act_q;
  assign match_stb  = ms_q;
  assign ovf_stb    = os_q;
endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_we,
  input logic         blk,
  input logic         pwm,
  input logic         ctc,
  input logic [1:0]   act,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cmp_q,
  input logic [W-1:0] top,
  input logic         wave_out,
  input logic         match_stb
);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt_q));
  // R3
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_out));
  // R4
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc && tick && !blk && !cnt_we && cnt_q == cmp_q) |=> (cnt_q == '0));
  // R6
  pwm_set_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && act == 2'b10 && tick && cnt_q == top) |=> wave_out);
  // R8
  top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && act == 2'b11 && tick && cnt_q == top) |=> !wave_out);
  // R11
  match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |-> $past(tick));
  // R12
  blocked_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tick) |=> !match_stb);
endmodule

bind tmr_wavegen tmr_wavegen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .blk(blk_q),
  .pwm(pwm), .ctc(ctc), .act(act_q), .cnt_q(cnt_r), .cmp_q(cmp_r),
  .top(top_v), .wave_out(wave_q), .match_stb(ms_q)
);

// File: tb/tmr_wavegen_test.sv
module tmr_wavegen_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ctl_we = 0, ext_we = 0, ext_wdata = 0, cmp_we = 0, cnt_we = 0;
  logic [7:0] ctl_wdata = 0, cmp_wdata = 0, cnt_wdata = 0;
  logic [7:0] ctl_rdata, cnt_q, cmp_active;
  logic wave_out, wave_oe, match_stb, ovf_stb;

  tmr_wavegen #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ctl_rdata(ctl_rdata), .cnt_q(cnt_q), .cmp_active(cmp_active),
    .wave_out(wave_out), .wave_oe(wave_oe), .match_stb(match_stb), .ovf_stb(ovf_stb)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    logic [7:0] cnt, cmpa;
    logic wave, oe, ms, os;
    string tag;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_cnt = 0, m_cmp = 0, m_buf = 0;
  logic [1:0] m_act = 0, m_wgl = 0;
  logic m_ext = 0, m_blk = 0, m_wave = 0;

  // pending writes for the next cycle
  bit p_ctl = 0, p_ext = 0, p_cmp = 0, p_cnt = 0;
  logic [7:0] d_ctl = 0, d_cmp = 0, d_cnt = 0;
  logic d_ext = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input string tag);
    exp_t e;
    logic pwm, ctc, hit, ptop, ovf;
    logic [7:0] top;
    logic nw;
    @(negedge clk);
    tick = tk;
    ctl_we = p_ctl; ctl_wdata = d_ctl;
    ext_we = p_ext; ext_wdata = d_ext;
    cmp_we = p_cmp; cmp_wdata = d_cmp;
    cnt_we = p_cnt; cnt_wdata = d_cnt;
    pwm  = ({m_ext, m_wgl} == 3'b011) || ({m_ext, m_wgl} == 3'b111);
    ctc  = ({m_ext, m_wgl} == 3'b010);
    top  = ({m_ext, m_wgl} == 3'b111) ? m_cmp : 8'hFF;
    hit  = tk && !m_blk && (m_cnt == m_cmp);
    ptop = tk && pwm && (m_cnt == top);
    ovf  = tk && (pwm ? (m_cnt == top) : (m_cnt == 8'hFF));
    nw = m_wave;
    if (!pwm) begin
      if (hit && m_act == 2'b01) nw = !m_wave;
      if (hit && m_act == 2'b10) nw = 1'b0;
      if (hit && m_act == 2'b11) nw = 1'b1;
    end else begin
      if (m_act == 2'b01 && m_ext && hit) nw = !m_wave;
      if (m_act == 2'b10) nw = ptop ? 1'b1 : (hit ? 1'b0 : m_wave);
      if (m_act == 2'b11) nw = ptop ? 1'b0 : (hit ? 1'b1 : m_wave);
    end
    if (p_cnt) m_cnt = d_cnt;
    else if (ptop || (ctc && hit)) m_cnt = 8'h00;
    else if (tk) m_cnt = m_cnt + 8'd1;
    if (p_cnt) m_blk = 1'b1; else if (tk) m_blk = 1'b0;
    if (p_cmp && !pwm) m_cmp = d_cmp;
    else if (ptop) m_cmp = m_buf;
    if (p_cmp) m_buf = d_cmp;
    if (p_ctl) begin m_act = d_ctl[7:6]; m_wgl = d_ctl[1:0]; end
    if (p_ext) m_ext = d_ext;
    m_wave = nw;
    e.cnt = m_cnt; e.cmpa = m_cmp; e.wave = m_wave; e.oe = (m_act != 2'b00);
    e.ms = hit; e.os = ovf; e.tag = tag;
    sbq.push_back(e);
    p_ctl = 0; p_ext = 0; p_cmp = 0; p_cnt = 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, tag);
  endtask

  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      chk(cnt_q == e.cnt, e.tag, "cnt", cnt_q, e.cnt);
      chk(cmp_active == e.cmpa, e.tag, "cmp_active", cmp_active, e.cmpa);
      chk(wave_out == e.wave, e.tag, "wave", wave_out, e.wave);
      chk(wave_oe == e.oe, e.tag, "oe", wave_oe, e.oe);
      chk(match_stb == e.ms, e.tag, "match_stb", match_stb, e.ms);
      chk(ovf_stb == e.os, e.tag, "ovf_stb", ovf_stb, e.os);
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_q == 0 && cmp_active == 0, "R1", "cnt/cmp", cnt_q, 0);
    chk(ctl_rdata == 0, "R1", "ctl_rdata", ctl_rdata, 0);
    chk(!wave_out && !wave_oe && !match_stb && !ovf_stb, "R1", "outs",
        {wave_out, wave_oe, match_stb, ovf_stb}, 0);

    // R2 readback, bits 5:2 read zero
    p_ctl = 1; d_ctl = 8'hFF; cyc(1'b0, "R2");
    @(posedge clk); #2;
    chk(ctl_rdata == 8'hC3, "R2", "ctl_rdata", ctl_rdata, 8'hC3);

    // R5 free-running toggle, R11 strobes over a full wrap
    p_ctl = 1; d_ctl = 8'h40; p_cmp = 1; d_cmp = 8'h05; p_cnt = 1; d_cnt = 8'h00;
    cyc(1'b0, "R5");
    run(300, "R5_R11");
    // R3 no tick: nothing moves
    for (int i = 0; i < 6; i++) cyc(1'b0, "R3");

    // R4 clear-on-compare with each action
    p_ctl = 1; d_ctl = 8'h42; p_cmp = 1; d_cmp = 8'h09; p_cnt = 1; d_cnt = 8'h00;
    cyc(1'b0, "R4");
    run(40, "R4");
    p_ctl = 1; d_ctl = 8'h82; cyc(1'b1, "R5"); run(20, "R5");
    p_ctl = 1; d_ctl = 8'hC2; cyc(1'b1, "R5"); run(20, "R5");

    // R12 counter load equal to compare blocks match and clear
    p_ctl = 1; d_ctl = 8'h42; cyc(1'b0, "R12");
    p_cnt = 1; d_cnt = 8'h09; cyc(1'b1, "R12");
    run(270, "R12");

    // R6 / R10 fast PWM, TOP = 0xFF, buffered compare
    p_ctl = 1; d_ctl = 8'h83; p_cmp = 1; d_cmp = 8'h40; p_cnt = 1; d_cnt = 8'h00;
    cyc(1'b0, "R6");
    run(20, "R6");
    p_cmp = 1; d_cmp = 8'h80; cyc(1'b1, "R10");
    run(560, "R10");
    p_ctl = 1; d_ctl = 8'hC3; cyc(1'b1, "R6"); run(300, "R6");

    // R7 toggle disabled with ext bit 0, R9 enable still high
    p_ctl = 1; d_ctl = 8'h43; cyc(1'b1, "R7"); run(300, "R7_R9");

    // R7 toggle with TOP = compare
    p_ext = 1; d_ext = 1'b1; p_cmp = 1; d_cmp = 8'h20; cyc(1'b1, "R7");
    run(300, "R7");

    // R8 compare equals TOP: only the TOP action
    p_ctl = 1; d_ctl = 8'h83; cyc(1'b1, "R8"); run(100, "R8");
    p_ctl = 1; d_ctl = 8'hC3; cyc(1'b1, "R8"); run(100, "R8");

    // R9 action 00 drops the enable
    p_ctl = 1; d_ctl = 8'h03; cyc(1'b1, "R9"); run(10, "R9");

    cyc(1'b0, "R3");
    @(posedge clk); #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule